// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external pins into interrupt requests. The two lower pins are level-capable. Each has a 2-bit sense code that selects a low level, any change, a falling edge or a rising edge. The top pin senses edges only. Its edges are caught by a flop clocked by the pin itself, so an edge is recorded even when the main clock is stopped, and that record can wake the device. Detection always uses the raw pin value. Driving a pin from the chip side therefore raises an interrupt in the same way as an external source.

Edge and any-change events set a sticky pending flag, and a one-cycle acknowledge clears it. A low-level request is not stored: it follows the pin. Each request passes through its own mask bit and then the global enable to form the single request output. While the device is in deep sleep, a low level on an armed level pin is sampled on a separate slow wake clock. Wake asserts only after two consecutive low samples. Wake is separate from the request, so a level that goes away after wake has asserted wakes the device but leaves no request behind.

All pins here are plain control signals. No data flows through the block, so there is no handshake at its edge.

Top module: `ext_irq_sense`

## Requirements
- R1: The code for level-capable pin i is sense_lvl_i[2i+1:2i]. 2'b00 selects low level, 2'b01 any change, 2'b10 falling edge and 2'b11 rising edge. Edges that the selected code does not name leave the flag untouched.
- R2: With code 2'b00, pend_o[i] equals the inverse of the synchronised pin. It drops once the pin returns high, with no acknowledge needed.
- R3: A pin change held for at least two clock cycles in a matching edge or change mode sets pend_o[i] within five cycles.
- R4: The top pin senses edges only. edge_rise_i=1 selects rising edges and 0 selects falling edges. The edge is captured asynchronously from the main clock.
- R5: irq_o is high exactly when gie_i is high and some bit of pend_o & mask_i is set.
- R6: A pending edge flag stays set until ack_i for that pin is high at a clock edge. An acknowledge in the same cycle as a new event leaves the flag set.
- R7: Changing a sense code, or edge_rise_i, creates no event. Flags already set stay set, except that entering level mode shows the live level instead.
- R8: During deep_sleep_i, a level pin in code 2'b00 with its mask bit set raises wake_o only after two consecutive low samples on rising edges of wclk_i. One low sample is not enough.
- R9: During deep_sleep_i with mask_i[2] set, a selected edge on the top pin raises wake_o while clk_i is stopped. The pending flag appears once the clock runs again, and wake_o then drops.
- R10: If the low level goes away after wake_o has asserted, wake_o stays high until the next wclk_i sample, but no pending flag or irq_o remains.
- R11: During and right after reset, pend_o, irq_o and wake_o are all zero, and every sense code reads as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Slow wake-sampling clock |
| pin_i | input | 3 | Raw pin values; bit 2 is the edge-only pin |
| sense_lvl_i | input | 4 | Two-bit sense codes for pins 0 and 1 |
| edge_rise_i | input | 1 | Edge select for pin 2: 1 rising, 0 falling |
| mask_i | input | 3 | Per-pin request enable |
| gie_i | input | 1 | Global interrupt enable |
| deep_sleep_i | input | 1 | Device is in the deepest sleep state |
| ack_i | input | 3 | One-cycle per-pin flag clear |
| pend_o | output | 3 | Per-pin pending or live level request |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
Random pin patterns run under random sense codes for each pin. This separates the four code meanings, because the same pin transition must set the flag under one code and leave it alone under another. Random acknowledge subsets and random mask and enable settings separate the sticky flags from the gated request. Directed cases place an acknowledge on the exact cycle of a new falling edge. They also count wake samples one at a time, one low sample against two. Finally, the main clock is halted while the edge-only pin toggles, which separates asynchronous capture from synchronous sampling.

// File: rtl/eis_pkg.sv
`timescale 1ns/1ps
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // True when the step from prev to cur matches the selected edge mode.
  function automatic logic edge_hit(sense_e m, logic prev, logic cur);
    logic r;
    case (m)
      SENSE_ANY:  r = prev ^ cur;
      SENSE_FALL: r = prev & ~cur;
      SENSE_RISE: r = ~prev & cur;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eis_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer; STAGES must be 2 or more.
module eis_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CW = STAGES * WIDTH;

  logic [CW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {CW{RST_VAL}};
    else         chain_q <= {chain_q[CW-WIDTH-1:0], d_i};
  end

  assign q_o = chain_q[CW-1 -: WIDTH];
endmodule

// File: rtl/eis_lvl_chan.sv
`timescale 1ns/1ps
// One level-capable pin: synchronizer, sample register, mode decode, sticky flag.
module eis_lvl_chan
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  input  logic       ack_i,
  output logic       req_o
);
  logic   pin_s;
  logic   samp_q;
  logic   pend_q;
  logic   hit;
  sense_e mode;
  sense_e mode_q;

  eis_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign mode = sense_e'(sense_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b1;
      mode_q <= SENSE_LOW;
    end else begin
      samp_q <= pin_s;
      mode_q <= mode;
    end
  end

  // An event only counts when the mode has been steady for a cycle.
  assign hit = (mode == mode_q) && edge_hit(mode, samp_q, pin_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (mode == SENSE_LOW) pend_q <= 1'b0;
    else                        pend_q <= hit | (pend_q & ~ack_i);
  end

  assign req_o = (mode == SENSE_LOW) ? ~pin_s : pend_q;
endmodule

// File: rtl/eis_edge_async.sv
`timescale 1ns/1ps
// Edge-only pin: the pin clocks a toggle flop, and the toggle is brought
// into the main clock domain to set a sticky flag.
module eis_edge_async #(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = SYNC_STAGES + 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  input  logic ack_i,
  output logic pend_o,
  output logic wake_req_o
);
  localparam int BW = $clog2(BLANK_CYCLES + 1);

  logic          eclk;
  logic          tog_q;
  logic          tog_s;
  logic          seen_q;
  logic          rise_q;
  logic [BW-1:0] blank_q;
  logic          hit;
  logic          pend_q;

  assign eclk = rise_i ? pin_i : ~pin_i;

  always_ff @(posedge eclk or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  eis_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tog_q),
    .q_o   (tog_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      rise_q  <= 1'b1;
      blank_q <= '0;
    end else begin
      seen_q <= tog_s;
      rise_q <= rise_i;
      if (rise_i != rise_q)  blank_q <= BW'(BLANK_CYCLES);
      else if (blank_q != 0) blank_q <= blank_q - 1'b1;
    end
  end

  // Toggles that arrive inside the blanking window after a select change
  // come from the select flip itself and are dropped.
  assign hit = (tog_s ^ seen_q) && (blank_q == 0) && (rise_i == rise_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= hit | (pend_q & ~ack_i);
  end

  assign pend_o     = pend_q;
  assign wake_req_o = tog_q ^ seen_q;
endmodule

// File: rtl/eis_wake_lvl.sv
`timescale 1ns/1ps
// Slow-clock confirmation of low levels for wake-up; SAMPLES must be 2 or more.
module eis_wake_lvl #(
  parameter int N       = 2,
  parameter int SAMPLES = 2
) (
  input  logic         wclk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] arm_i,
  output logic         wake_o
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [SAMPLES-1:0] sh_q;
    always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SAMPLES-2:0], arm_i[g] & ~pin_i[g]};
    end
    assign hit[g] = &sh_q;
  end

  assign wake_o = |hit;
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense #(
  parameter int N_LVL       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_SAMP   = 2,
  localparam int NP         = N_LVL + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wclk_i,
  input  logic [NP-1:0]    pin_i,
  input  logic [2*N_LVL-1:0] sense_lvl_i,
  input  logic             edge_rise_i,
  input  logic [NP-1:0]    mask_i,
  input  logic             gie_i,
  input  logic             deep_sleep_i,
  input  logic [NP-1:0]    ack_i,
  output logic [NP-1:0]    pend_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [N_LVL-1:0] arm;
  logic             lvl_wake;
  logic             edge_wake;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    eis_lvl_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[g]),
      .sense_i(sense_lvl_i[2*g +: 2]),
      .ack_i  (ack_i[g]),
      .req_o  (pend_o[g])
    );
    assign arm[g] = mask_i[g] & deep_sleep_i & (sense_lvl_i[2*g +: 2] == 2'b00);
  end

  eis_edge_async #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_i[NP-1]),
    .rise_i    (edge_rise_i),
    .ack_i     (ack_i[NP-1]),
    .pend_o    (pend_o[NP-1]),
    .wake_req_o(edge_wake)
  );

  eis_wake_lvl #(.N(N_LVL), .SAMPLES(WAKE_SAMP)) u_wake (
    .wclk_i(wclk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i[N_LVL-1:0]),
    .arm_i (arm),
    .wake_o(lvl_wake)
  );

  assign irq_o  = gie_i & |(pend_o & mask_i);
  assign wake_o = deep_sleep_i & (lvl_wake | (edge_wake & mask_i[NP-1]));
endmodule

// File: rtl/eis_checker.sv
`timescale 1ns/1ps
module eis_checker #(
  parameter int NP = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gie_i,
  input logic          deep_sleep_i,
  input logic [NP-1:0] mask_i,
  input logic [NP-1:0] ack_i,
  input logic [NP-1:0] pend_o,
  input logic          irq_o,
  input logic          wake_o
);
  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  p_irq_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_o & mask_i) != '0));

  p_edge_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[NP-1] && !ack_i[NP-1]) |=> pend_o[NP-1]);

  p_wake_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deep_sleep_i |-> !wake_o);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r11: assert (pend_o == '0 && !irq_o && !wake_o)
        else $error("outputs not clear in reset");
    end
  end
endmodule

bind ext_irq_sense eis_checker #(.NP(NP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gie_i       (gie_i),
  .deep_sleep_i(deep_sleep_i),
  .mask_i      (mask_i),
  .ack_i       (ack_i),
  .pend_o      (pend_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;
  logic       clk_raw = 1'b0;
  logic       clk_en  = 1'b1;
  logic       clk;
  logic       rst_n, wclk;
  logic [2:0] pin, mask, ack, pend;
  logic [3:0] sense;
  logic       rise, gie, sleep, irq, wake;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [2:0] pin_m, pend_m;
  logic [3:0] code_m;
  logic       rise_m;

  always #2.5 clk_raw = ~clk_raw;
  assign clk = clk_raw & clk_en;

  ext_irq_sense u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wclk_i(wclk), .pin_i(pin),
    .sense_lvl_i(sense), .edge_rise_i(rise), .mask_i(mask), .gie_i(gie),
    .deep_sleep_i(sleep), .ack_i(ack), .pend_o(pend), .irq_o(irq), .wake_o(wake)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_raw);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wpulse();
    wclk = 1'b1; #20; wclk = 1'b0; #20;
  endtask

  function automatic logic hit_f(logic [1:0] c, logic o, logic n);
    case (c)
      2'b01:   return o != n;
      2'b10:   return o & ~n;
      2'b11:   return ~o & n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] view_f();
    logic [2:0] v;
    for (int i = 0; i < 2; i++)
      v[i] = (code_m[2*i +: 2] == 2'b00) ? ~pin_m[i] : pend_m[i];
    v[2] = pend_m[2];
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_raw);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] np, a;
    void'($urandom(32'd20240611));
    rst_n = 0; wclk = 0; pin = 3'b111; sense = 4'b0000; rise = 1'b1;
    mask = 3'b000; gie = 0; sleep = 0; ack = 3'b000;
    step(2);
    chk("R11 reset pend", pend, 3'b000);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset wake", wake, 0);
    rst_n = 1;
    step(4);
    chk("R11 after reset pend", pend, 3'b000);

    // level mode follows pin with no ack (R2)
    pin[1] = 1'b0; step(4);
    chk("R2 level low", pend, 3'b010);
    pin[1] = 1'b1; step(4);
    chk("R2 level released", pend, 3'b000);

    // falling edge mode on pin 0 (R1, R3, R6)
    sense = 4'b0010; step(6);
    chk("R7 mode switch", pend, 3'b000);
    pin[0] = 1'b0; step(5);
    chk("R3 falling edge", pend[0], 1);
    pin[0] = 1'b1; step(5);
    chk("R1 rising ignored in fall mode", pend[0], 1);
    pin[0] = 1'b0; step(2);
    ack = 3'b001; step(1); ack = 3'b000; step(3);
    chk("R6 ack with new event", pend[0], 1);
    ack = 3'b001; step(1); ack = 3'b000; step(1);
    chk("R6 ack clears", pend[0], 0);

    pin_m = pin; pend_m = 3'b000; code_m = sense; rise_m = rise;

    for (int it = 0; it < 60; it++) begin
      if ($urandom % 3 == 0) begin
        logic [3:0] nc;
        nc = 4'($urandom);
        for (int i = 0; i < 2; i++)
          if (nc[2*i +: 2] == 2'b00) pend_m[i] = 1'b0;
        code_m = nc; rise_m = 1'($urandom);
        sense = code_m; rise = rise_m;
        step(7);
        chk("R7 code change no event", pend, view_f());
      end
      np = 3'($urandom);
      for (int i = 0; i < 2; i++)
        if (hit_f(code_m[2*i +: 2], pin_m[i], np[i])) pend_m[i] = 1'b1;
      if (rise_m ? (~pin_m[2] & np[2]) : (pin_m[2] & ~np[2])) pend_m[2] = 1'b1;
      pin_m = np; pin = np;
      step(5);
      chk("R3 R4 random edges", pend, view_f());
      a = 3'($urandom);
      ack = a; step(1); ack = 3'b000;
      for (int i = 0; i < 2; i++)
        if (code_m[2*i +: 2] != 2'b00) pend_m[i] = pend_m[i] & ~a[i];
      pend_m[2] = pend_m[2] & ~a[2];
      step(1);
      chk("R6 random ack", pend, view_f());
      mask = 3'($urandom); gie = 1'($urandom);
      step(1);
      chk("R5 gated request", irq, gie & |(view_f() & mask));
    end

    // level wake from deep sleep (R8, R10)
    pin = 3'b111; sense = 4'b0000; rise = 1'b1; mask = 3'b000; gie = 1;
    step(7);
    ack = 3'b111; step(1); ack = 3'b000; step(1);
    chk("R6 cleanup", pend, 3'b000);
    sleep = 1; mask = 3'b001; pin[0] = 1'b0; step(4);
    wpulse();
    chk("R8 one sample no wake", wake, 0);
    wpulse();
    chk("R8 two samples wake", wake, 1);
    chk("R5 level request", irq, 1);
    pin[0] = 1'b1; step(4);
    chk("R10 level gone no request", irq, 0);
    chk("R10 pend cleared", pend[0], 0);
    chk("R10 wake still held", wake, 1);
    wpulse();
    chk("R10 wake drops on resample", wake, 0);

    // edge wake with the main clock stopped (R4, R9)
    mask = 3'b100; pin[2] = 1'b0; step(7);
    ack = 3'b100; step(1); ack = 3'b000; step(1);
    chk("R4 falling ignored in rise mode", pend[2], 0);
    clk_en = 1'b0;
    #1 pin[2] = 1'b1;
    #20;
    chk("R9 wake with clock stopped", wake, 1);
    chk("R9 no flag while stopped", pend[2], 0);
    @(negedge clk_raw); clk_en = 1'b1;
    step(5);
    chk("R9 flag after restart", pend[2], 1);
    chk("R9 wake released", wake, 0);
    chk("R5 edge request", irq, 1);
    gie = 0; step(1);
    chk("R5 global disable", irq, 0);
    sleep = 0; step(1);
    chk("R8 awake no wake", wake, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule